// File: doc/BRIEF.md
# Parallel GPIO Bank with Bus Override

This block turns up to 46 shared pads into general-purpose pins. The pads also carry the external memory bus and the host port. The pins are grouped into sets of 16. Each set has three registers: an enable word, a direction word and a data word. A pad drives a value only when its enable bit and its direction bit are both 1. It then drives the stored data bit. When both bits are 0 the pad is an input, and its data bit follows the pad level on every clock.

A single port-mode input decides who owns the pads. When it is 1, the memory and host bus logic owns them: its output-enable and output-value vectors pass straight to the pads, whatever the GPIO registers hold. In this mode the registers can still be read and written, but they neither drive pads nor capture pad levels. Other settings (enable and direction not equal) are treated as safe inputs and raise a sticky flag that stays set until reset.

The register port is a simple word-indexed write strobe with a combinational read mux.

Top module: `pgpio_bank`

## Requirements
- R1: Register offset 3*s+0 selects the enable word of set s, 3*s+1 its direction word and 3*s+2 its data word. Any offset at or above 3 times the set count reads 0, and a write to such an offset changes no register.
- R2: Bit b of set s belongs to pad 16*s+b. The last set holds pads 32 to 45 in bits 13:0.
- R3: Bits 15:14 of the last set's three words are storage bits that reset to 0, read back what was written and affect no pad.
- R4: After reset every enable and direction bit reads 0, and the pads are not driven while port_mode is 0.
- R5: On the first clock edge after reset is released, every data bit loads the level of its pad, whatever port_mode is.
- R6: With port_mode 0 and both enable and direction bits at 1, pad_oe is 1 and pad_out equals the data bit. A write to that data word shows on pad_out right after the write edge.
- R7: With port_mode 0 and both enable and direction bits at 0, the data bit loads its pad level on every clock edge. A write to that bit has no effect, because the pad level wins.
- R8: With port_mode 1, pad_oe equals bus_oe and pad_out equals bus_out for every pad, whatever the register contents.
- R9: With port_mode 1, all registers can still be written and read back, and data bits do not capture pad levels.
- R10: A pad whose enable and direction bits differ is not driven, its data bit captures the pad level while port_mode is 0, and cfg_mismatch becomes 1 on the next edge.
- R11: Once set, cfg_mismatch stays 1 until reset, even after the bits agree again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_mode | input | 1 | 1: pads owned by the memory/host bus, 0: pads are GPIO |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| bus_oe | input | 46 | Output enables from the memory/host bus logic |
| bus_out | input | 46 | Output values from the memory/host bus logic |
| pad_in | input | 46 | Sampled pad levels |
| pad_oe | output | 46 | Pad output enables |
| pad_out | output | 46 | Pad output values |
| cfg_mismatch | output | 1 | Sticky flag: some enable bit and direction bit have differed |

## Verification
The bench builds the block with its default parameters: 46 pads in sets of 16. This gives three full register triplets and a last set that is only partly populated. With these values the reserved top bits of the last set, the unused offsets 9 to 15 and the pad-to-bit mapping across all three sets can all be checked. Reset is applied while port_mode is 1, so the first-edge seeding of the data words is seen apart from normal input capture. The bench then walks through output, input, mismatched and bus-owned states.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;
  // Offset of a word inside one set's triplet
  typedef enum logic [1:0] {
    FLD_EN  = 2'd0,
    FLD_DIR = 2'd1,
    FLD_DAT = 2'd2
  } pgpio_fld_e;

  localparam int FLDS_PER_SET = 3;

  // Number of pads that set s actually carries
  function automatic int pads_in_set(int num_pins, int set_w, int s);
    int rest;
    rest = num_pins - s * set_w;
    return (rest >= set_w) ? set_w : rest;
  endfunction
endpackage

// File: rtl/pgpio_set.sv
module pgpio_set #(
  parameter int SET_W = 16,
  parameter int PINS  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed,
  input  logic             bus_mode,
  input  logic             wr_en,
  input  logic             wr_dir,
  input  logic             wr_dat,
  input  logic [SET_W-1:0] wdata,
  input  logic [SET_W-1:0] pin_in,
  output logic [SET_W-1:0] en_q,
  output logic [SET_W-1:0] dir_q,
  output logic [SET_W-1:0] dat_q
);
  // Bits at or above PINS are plain storage with no pad behind them
  localparam logic [SET_W-1:0] PIN_MASK = {SET_W{1'b1}} >> (SET_W - PINS);

  logic [SET_W-1:0] en_d, dir_d, dat_d, cap;

  always_comb begin
    cap   = PIN_MASK & ({SET_W{seed}} |
                        ({SET_W{~bus_mode}} & ~(en_q & dir_q)));
    en_d  = wr_en  ? wdata : en_q;
    dir_d = wr_dir ? wdata : dir_q;
    dat_d = wr_dat ? wdata : dat_q;
    // a captured pad level overrides a write in the same cycle
    dat_d = (dat_d & ~cap) | (pin_in & cap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      en_q  <= en_d;
      dir_q <= dir_d;
      dat_q <= dat_d;
    end
  end
endmodule

// File: rtl/pgpio_pad_mux.sv
module pgpio_pad_mux #(
  parameter int NUM_PINS = 46
) (
  input  logic                bus_mode,
  input  logic [NUM_PINS-1:0] gpio_drv,
  input  logic [NUM_PINS-1:0] gpio_val,
  input  logic [NUM_PINS-1:0] bus_oe,
  input  logic [NUM_PINS-1:0] bus_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
    assign pad_oe[i]  = bus_mode ? bus_oe[i]  : gpio_drv[i];
    assign pad_out[i] = bus_mode ? bus_out[i] : gpio_val[i];
  end
endmodule

// File: rtl/pgpio_bank.sv
module pgpio_bank #(
  parameter int NUM_PINS = 46,
  parameter int SET_W    = 16,
  localparam int NUM_SETS = (NUM_PINS + SET_W - 1) / SET_W,
  localparam int NUM_REGS = pgpio_pkg::FLDS_PER_SET * NUM_SETS,
  localparam int AW       = $clog2(NUM_REGS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                port_mode,
  input  logic                reg_wr,
  input  logic [AW-1:0]       reg_addr,
  input  logic [SET_W-1:0]    reg_wdata,
  output logic [SET_W-1:0]    reg_rdata,
  input  logic [NUM_PINS-1:0] bus_oe,
  input  logic [NUM_PINS-1:0] bus_out,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic                cfg_mismatch
);
  import pgpio_pkg::*;

  localparam int PADDED = NUM_SETS * SET_W;

  logic              seed_q, seed_d;
  logic              mis_q, mis_d;
  logic [PADDED-1:0] pin_pad, en_w, dir_w, dat_w;
  logic [NUM_PINS-1:0] en_all, dir_all, dat_all, drv_all;

  always_comb begin
    pin_pad = '0;
    pin_pad[NUM_PINS-1:0] = pad_in;
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    localparam int BASE = FLDS_PER_SET * s;
    logic sel_en, sel_dir, sel_dat;
    assign sel_en  = reg_wr && (reg_addr == AW'(BASE + int'(FLD_EN)));
    assign sel_dir = reg_wr && (reg_addr == AW'(BASE + int'(FLD_DIR)));
    assign sel_dat = reg_wr && (reg_addr == AW'(BASE + int'(FLD_DAT)));

    pgpio_set #(
      .SET_W(SET_W),
      .PINS (pads_in_set(NUM_PINS, SET_W, s))
    ) set_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .seed    (seed_q),
      .bus_mode(port_mode),
      .wr_en   (sel_en),
      .wr_dir  (sel_dir),
      .wr_dat  (sel_dat),
      .wdata   (reg_wdata),
      .pin_in  (pin_pad[s*SET_W +: SET_W]),
      .en_q    (en_w[s*SET_W +: SET_W]),
      .dir_q   (dir_w[s*SET_W +: SET_W]),
      .dat_q   (dat_w[s*SET_W +: SET_W])
    );
  end

  // Read mux: unmatched offsets return zero
  always_comb begin
    reg_rdata = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (reg_addr == AW'(FLDS_PER_SET * s + int'(FLD_EN)))
        reg_rdata = en_w[s*SET_W +: SET_W];
      if (reg_addr == AW'(FLDS_PER_SET * s + int'(FLD_DIR)))
        reg_rdata = dir_w[s*SET_W +: SET_W];
      if (reg_addr == AW'(FLDS_PER_SET * s + int'(FLD_DAT)))
        reg_rdata = dat_w[s*SET_W +: SET_W];
    end
  end

  assign en_all  = en_w[NUM_PINS-1:0];
  assign dir_all = dir_w[NUM_PINS-1:0];
  assign dat_all = dat_w[NUM_PINS-1:0];
  assign drv_all = en_all & dir_all;

  always_comb begin
    seed_d = 1'b0;
    mis_d  = mis_q | (|(en_all ^ dir_all));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q <= 1'b1;
      mis_q  <= 1'b0;
    end else begin
      seed_q <= seed_d;
      mis_q  <= mis_d;
    end
  end

  assign cfg_mismatch = mis_q;

  pgpio_pad_mux #(.NUM_PINS(NUM_PINS)) mux_i (
    .bus_mode(port_mode),
    .gpio_drv(drv_all),
    .gpio_val(dat_all),
    .bus_oe  (bus_oe),
    .bus_out (bus_out),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
  );
endmodule

// File: rtl/pgpio_bank_chk.sv
module pgpio_bank_chk #(
  parameter int NUM_PINS = 46,
  parameter int SET_W    = 16,
  parameter int NUM_REGS = 9,
  parameter int AW       = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                port_mode,
  input logic                reg_wr,
  input logic [AW-1:0]       reg_addr,
  input logic [SET_W-1:0]    reg_rdata,
  input logic [NUM_PINS-1:0] bus_oe,
  input logic [NUM_PINS-1:0] bus_out,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic                cfg_mismatch,
  input logic                seed,
  input logic [NUM_PINS-1:0] en_all,
  input logic [NUM_PINS-1:0] dir_all,
  input logic [NUM_PINS-1:0] dat_all
);
  // R8
  bus_owns_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_mode |-> (pad_oe == bus_oe) && (pad_out == bus_out));

  // R11
  mismatch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mismatch |=> cfg_mismatch);

  // R7
  input_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(port_mode) |->
      (((dat_all ^ $past(pad_in)) & ~$past(en_all & dir_all)) == '0));

  // R9
  bus_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(port_mode) && !$past(seed) && !$past(reg_wr)) |-> $stable(dat_all));

  // R1
  unused_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= NUM_REGS) |-> (reg_rdata == '0));

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr) |-> ($stable(en_all) && $stable(dir_all)));
endmodule

bind pgpio_bank pgpio_bank_chk #(
  .NUM_PINS(NUM_PINS),
  .SET_W   (SET_W),
  .NUM_REGS(NUM_REGS),
  .AW      (AW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_mode   (port_mode),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata),
  .bus_oe      (bus_oe),
  .bus_out     (bus_out),
  .pad_in      (pad_in),
  .pad_oe      (pad_oe),
  .pad_out     (pad_out),
  .cfg_mismatch(cfg_mismatch),
  .seed        (seed_q),
  .en_all      (en_all),
  .dir_all     (dir_all),
  .dat_all     (dat_all)
);

// File: tb/pgpio_bank_tb.sv
module pgpio_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 46;
  localparam int SW = 16;
  localparam logic [NP-1:0] BUS_E = 46'h2AAA_AAAA_AAAA;
  localparam logic [NP-1:0] BUS_O = 46'h1555_5555_5555;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          port_mode = 1'b1;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [SW-1:0] reg_wdata = '0;
  logic [SW-1:0] reg_rdata;
  logic [NP-1:0] bus_oe = BUS_E;
  logic [NP-1:0] bus_out = BUS_O;
  logic [NP-1:0] pad_in = 46'h1234_5678_9ABC;
  logic [NP-1:0] pad_oe, pad_out;
  logic          cfg_mismatch;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgpio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .port_mode(port_mode),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_oe(bus_oe), .bus_out(bus_out),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .cfg_mismatch(cfg_mismatch)
  );

  typedef struct {
    int          kind;   // 0 rdata, 1 pad_oe, 2 pad_out, 3 mismatch
    logic [63:0] mask;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];

  // Monitor: pops one expected item per falling edge and compares
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = 64'(reg_rdata);
        1: act = 64'(pad_oe);
        2: act = 64'(pad_out);
        default: act = 64'(cfg_mismatch);
      endcase
      n_run++;
      if (((act ^ it.exp) & it.mask) != 0) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag,
                 act & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [SW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [63:0] mask,
                             input logic [63:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.mask = mask; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic rd(input logic [3:0] a, input logic [SW-1:0] exp,
                    input string tag);
    reg_addr = a;
    expect_item(0, 64'hFFFF, 64'(exp), tag);
  endtask

  localparam logic [63:0] ALL = 64'h3FFF_FFFF_FFFF;

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (2) tick();
    // reset state, seeding while the bus owns the pads
    rd(4'd0, 16'h0000, "R4 enable set0 after reset");
    rd(4'd1, 16'h0000, "R4 direction set0 after reset");
    rd(4'd2, 16'h9ABC, "R5 data set0 seeded");
    rd(4'd5, 16'h5678, "R5 data set1 seeded");
    rd(4'd8, 16'h1234, "R5 data set2 seeded");
    expect_item(1, ALL, 64'(BUS_E), "R8 pad_oe from bus");
    expect_item(2, ALL, 64'(BUS_O), "R8 pad_out from bus");
    expect_item(3, 64'h1, 64'h0, "R4 mismatch clear after reset");

    // bus mode: no capture, registers still writable
    pad_in = 46'h0000_FFFF_0000;
    tick();
    rd(4'd2, 16'h9ABC, "R9 data held in bus mode");
    wr(4'd0, 16'hFFFF);
    wr(4'd1, 16'hFFFF);
    expect_item(1, ALL, 64'(BUS_E), "R8 enables do not override bus");
    rd(4'd0, 16'hFFFF, "R9 enable writable in bus mode");

    // GPIO mode: set0 outputs, set1 inputs
    port_mode = 1'b0;
    expect_item(1, ALL, 64'h0000_0000_FFFF, "R6 R4 set0 drives");
    expect_item(2, 64'hFFFF, 64'h9ABC, "R6 pad_out holds data");
    wr(4'd2, 16'h00F0);
    expect_item(2, 64'hFFFF, 64'h00F0, "R6 data write reaches pads");
    rd(4'd2, 16'h00F0, "R6 data readback");
    rd(4'd5, 16'hFFFF, "R7 R2 set1 captures pads 31:16");
    wr(4'd5, 16'h1234);
    rd(4'd5, 16'hFFFF, "R7 write to input bits ignored");

    // mismatched configuration on pad 16
    wr(4'd3, 16'h0001);
    expect_item(1, ALL, 64'h0000_0000_FFFF, "R10 mismatched pad undriven");
    expect_item(3, 64'h1, 64'h1, "R10 mismatch flag set");
    pad_in = 46'h0000_FFFE_0000;
    tick();
    rd(4'd5, 16'hFFFE, "R10 mismatched pad captures level");
    wr(4'd4, 16'h0001);
    expect_item(1, ALL, 64'h0000_0001_FFFF, "R6 pad16 drives once agreed");
    expect_item(3, 64'h1, 64'h1, "R11 mismatch stays set");

    // last set: reserved bits and pad mapping
    wr(4'd6, 16'hFFFF);
    wr(4'd7, 16'hFFFF);
    wr(4'd8, 16'hC005);
    rd(4'd6, 16'hFFFF, "R3 enable set2 reserved bits");
    rd(4'd7, 16'hFFFF, "R3 direction set2 reserved bits");
    rd(4'd8, 16'hC005, "R3 data set2 reserved bits");
    expect_item(1, ALL, 64'h3FFF_0001_FFFF, "R2 R3 pad_oe mapping");
    expect_item(2, 64'h3FFF_0001_FFFF, 64'h0005_0000_00F0,
                "R2 pad_out mapping");

    // unused offsets
    wr(4'd9, 16'hBEEF);
    rd(4'd9, 16'h0000, "R1 offset 9 reads zero");
    rd(4'd15, 16'h0000, "R1 offset 15 reads zero");
    rd(4'd0, 16'hFFFF, "R1 write to offset 9 changed nothing");

    // hand pads back to the bus
    port_mode = 1'b1;
    expect_item(1, ALL, 64'(BUS_E), "R8 bus regains pads");
    expect_item(2, ALL, 64'(BUS_O), "R8 bus values on pads");
    rd(4'd8, 16'hC005, "R9 registers kept in bus mode");

    repeat (2) tick();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule